// File: doc/BRIEF.md
# Supervisory Reset and Secondary-Rail Fail Generator

This block turns two digitized supply comparator results into the system reset and a fail flag for a second rail. One input reports that the primary supply is below its trip level. The other reports that a secondary rail is below its own trip level. Both inputs come from the analog domain, so each passes through a two-flop synchronizer before any logic uses it.

The reset is held while the primary supply is low. After the supply recovers, the reset is held for a further power-up timeout before it releases. A two-bit select chooses one of four timeouts, and the timeout is counted in pulses of a prescaled millisecond tick. If the supply dips again while the timeout is running, the count is abandoned and starts from zero on the next recovery. The select is captured when a timeout period begins, so a change made partway through only applies to the next period. The secondary fail flag has no timeout: it follows the synchronized comparator directly.

Top module: `supv_reset_top`

## Requirements
- R1: While the synchronized primary-low input is 1, `sysRst` is 1 in the following cycle. A single-cycle low pulse on `priLowRaw` therefore still asserts reset.
- R2: After the synchronized primary-low input returns to 0, `sysRst` stays at 1 until the selected number of `msTick` pulses has been counted, then falls to 0.
- R3: The `timeoutSel` encoding, in `msTick` pulses, is: 2'b00 = 50, 2'b01 = 200, 2'b10 = 400, 2'b11 = 800.
- R4: `sysRst` is 1 from the assertion of `rstN` through power-up, until the first timeout period completes.
- R5: `sysRstN` is always the complement of `sysRst`.
- R6: `secFailN` is 0 while the secondary rail is below its trip level and 1 otherwise. It has no timeout and does not depend on the reset state.
- R7: If the primary supply drops again while a timeout is running, the tick count clears. The next recovery starts a full timeout from zero.
- R8: Both comparator inputs pass through two flops. A change on `secLowRaw` reaches `secFailN` after exactly two clock edges, and both sync stages reset to "below trip".
- R9: `timeoutSel` is sampled only in the cycle a timeout period begins. A change made during a running period does not alter that period's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| priLowRaw | input | 1 | Primary supply below trip 1 (asynchronous) |
| secLowRaw | input | 1 | Secondary rail below trip 2 (asynchronous) |
| timeoutSel | input | 2 | Power-up timeout select |
| msTick | input | 1 | One-cycle pulse per millisecond |
| sysRst | output | 1 | System reset, active high |
| sysRstN | output | 1 | System reset, active low |
| secFailN | output | 1 | Secondary-rail fail, low while the rail is low |

## Verification
The assertions assume the following about the inputs:
- `msTick` is a one-cycle pulse.
- The comparator inputs are level signals whose synchronized copies can be lined up with their raw values two edges earlier.
- `timeoutSel` is stable on the edge where a period starts.

The stimulus drives every input on the falling clock edge, so each value is stable at the sampling edge. It generates the tick as a single-cycle pulse every four clocks. It changes the select only well away from recovery edges, except in the deliberate case where the select is changed mid-period.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } supvState_e;

  typedef struct packed {
    logic clrCnt;
    logic loadSel;
    logic cntEn;
  } supvStrobe_t;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/supv_datapath.sv
module supv_datapath import supv_pkg::*; #(
  parameter int LIM_SEL0 = 50,
  parameter int LIM_SEL1 = 200,
  parameter int LIM_SEL2 = 400,
  parameter int LIM_SEL3 = 800,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        priLowRaw,
  input  logic        secLowRaw,
  input  logic [1:0]  timeoutSel,
  input  logic        msTick,
  input  supvStrobe_t strobe,
  output logic        priLowS,
  output logic        secLowS,
  output logic        cntDone
);

  localparam int LIM_MAX01 = (LIM_SEL0 > LIM_SEL1) ? LIM_SEL0 : LIM_SEL1;
  localparam int LIM_MAX23 = (LIM_SEL2 > LIM_SEL3) ? LIM_SEL2 : LIM_SEL3;
  localparam int LIM_MAX   = (LIM_MAX01 > LIM_MAX23) ? LIM_MAX01 : LIM_MAX23;
  localparam int CW        = $clog2(LIM_MAX + 1);

  localparam logic [CW-1:0] LIM0 = CW'(LIM_SEL0);
  localparam logic [CW-1:0] LIM1 = CW'(LIM_SEL1);
  localparam logic [CW-1:0] LIM2 = CW'(LIM_SEL2);
  localparam logic [CW-1:0] LIM3 = CW'(LIM_SEL3);

  logic [1:0]    syncOut;
  logic [CW-1:0] limitQ;
  logic [CW-1:0] limitSel;
  logic [CW-1:0] cntQ;

  // both comparators start out as "below trip"
  supv_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({secLowRaw, priLowRaw}),
    .dout(syncOut)
  );

  assign priLowS = syncOut[0];
  assign secLowS = syncOut[1];

  always_comb begin
    unique case (timeoutSel)
      2'b00:   limitSel = LIM0;
      2'b01:   limitSel = LIM1;
      2'b10:   limitSel = LIM2;
      default: limitSel = LIM3;
    endcase
  end

  // limit captured only at the start of a period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               limitQ <= LIM0;
    else if (strobe.loadSel) limitQ <= limitSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.clrCnt) begin
      cntQ <= '0;
    end else if (strobe.cntEn && msTick && (cntQ != limitQ)) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign cntDone = (cntQ == limitQ);

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl import supv_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        priLowS,
  input  logic        cntDone,
  output supvStrobe_t strobe,
  output logic        rstActive
);

  supvState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_HOLD: begin
        strobe.clrCnt = 1'b1;
        if (!priLowS) begin
          stateD         = ST_COUNT;
          strobe.loadSel = 1'b1;
        end
      end
      ST_COUNT: begin
        if (priLowS) begin
          stateD        = ST_HOLD;
          strobe.clrCnt = 1'b1;
        end else if (cntDone) begin
          stateD = ST_RUN;
        end else begin
          strobe.cntEn = 1'b1;
        end
      end
      ST_RUN: begin
        if (priLowS) stateD = ST_HOLD;
      end
      default: begin
        stateD        = ST_HOLD;
        strobe.clrCnt = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_HOLD;
      rstActive <= 1'b1;
    end else begin
      stateQ    <= stateD;
      rstActive <= (stateD != ST_RUN);
    end
  end

endmodule

// File: rtl/supv_reset_top.sv
module supv_reset_top import supv_pkg::*; #(
  parameter int LIM_SEL0 = 50,
  parameter int LIM_SEL1 = 200,
  parameter int LIM_SEL2 = 400,
  parameter int LIM_SEL3 = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       priLowRaw,
  input  logic       secLowRaw,
  input  logic [1:0] timeoutSel,
  input  logic       msTick,
  output logic       sysRst,
  output logic       sysRstN,
  output logic       secFailN
);

  supvStrobe_t strobe;
  logic        priLowS;
  logic        secLowS;
  logic        cntDone;
  logic        rstActive;

  supv_datapath #(
    .LIM_SEL0(LIM_SEL0),
    .LIM_SEL1(LIM_SEL1),
    .LIM_SEL2(LIM_SEL2),
    .LIM_SEL3(LIM_SEL3),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .priLowRaw (priLowRaw),
    .secLowRaw (secLowRaw),
    .timeoutSel(timeoutSel),
    .msTick    (msTick),
    .strobe    (strobe),
    .priLowS   (priLowS),
    .secLowS   (secLowS),
    .cntDone   (cntDone)
  );

  supv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .priLowS  (priLowS),
    .cntDone  (cntDone),
    .strobe   (strobe),
    .rstActive(rstActive)
  );

  assign sysRst   = rstActive;
  assign sysRstN  = ~rstActive;
  assign secFailN = ~secLowS;

endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter int MIN_TICKS = 50
) (
  input logic clk,
  input logic rstN,
  input logic priLowS,
  input logic secLowRaw,
  input logic msTick,
  input logic sysRst,
  input logic sysRstN,
  input logic secFailN
);

  logic [1:0]  sinceRst;
  logic [15:0] ticksSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || priLowS) begin
      ticksSeen <= '0;
    end else if (sysRst && msTick && (ticksSeen != 16'hFFFF)) begin
      ticksSeen <= ticksSeen + 1'b1;
    end
  end

  AST_LOW_FORCES_RESET: assert property (@(posedge clk) disable iff (!rstN) priLowS |=> sysRst); // R1

  AST_RELEASE_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN) $fell(sysRst) |-> (ticksSeen >= 16'(MIN_TICKS))); // R2

  AST_POLARITY_PAIR: assert property (@(posedge clk) disable iff (!rstN) sysRst != sysRstN); // R5

  AST_SEC_TWO_EDGE_LAG: assert property (@(posedge clk) disable iff (!rstN) (sinceRst == 2'd3) |-> (secFailN == !$past(secLowRaw, 2))); // R8

endmodule

bind supv_reset_top supv_reset_chk #(.MIN_TICKS(LIM_SEL0)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .priLowS  (priLowS),
  .secLowRaw(secLowRaw),
  .msTick   (msTick),
  .sysRst   (sysRst),
  .sysRstN  (sysRstN),
  .secFailN (secFailN)
);

// File: tb/tb_supv_reset_top.sv
`timescale 1ns/1ps
module tb_supv_reset_top;

  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       priLowRaw;
  logic       secLowRaw;
  logic [1:0] timeoutSel;
  logic       msTick;
  logic       sysRst;
  logic       sysRstN;
  logic       secFailN;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string reqTag = "R4";

  // behavioural reference state
  logic pA, pB, sA, sB;
  bit   released;
  bit   timing;
  int   ticks;
  int   goal;
  bit   expRst;

  always #4 clk = ~clk;

  supv_reset_top dut (
    .clk       (clk),
    .rstN      (rstN),
    .priLowRaw (priLowRaw),
    .secLowRaw (secLowRaw),
    .timeoutSel(timeoutSel),
    .msTick    (msTick),
    .sysRst    (sysRst),
    .sysRstN   (sysRstN),
    .secFailN  (secFailN)
  );

  function automatic int goalFor(logic [1:0] s);
    case (s)
      2'b00:   return 50;
      2'b01:   return 200;
      2'b10:   return 400;
      default: return 800;
    endcase
  endfunction

  // tick generator, driven on the falling edge
  int divCnt = 0;
  always @(negedge clk) begin
    divCnt = (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    msTick = (divCnt == 0);
  end

  // reference model: advances on each rising edge
  always @(posedge clk) begin
    logic lowNow;
    if (!rstN) begin
      pA = 1; pB = 1; sA = 1; sB = 1;
      released = 0; timing = 0; ticks = 0; goal = 50;
    end else begin
      lowNow = pB;
      pB = pA; pA = priLowRaw;
      sB = sA; sA = secLowRaw;
      if (lowNow) begin
        released = 0; timing = 0; ticks = 0;
      end else if (!released && !timing) begin
        timing = 1; ticks = 0; goal = goalFor(timeoutSel);
      end else if (timing) begin
        if (ticks == goal) begin
          timing = 0; released = 1;
        end else if (msTick) begin
          ticks++;
        end
      end
    end
    expRst = !released;
  end

  // compare on the falling edge
  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      checks++;
      if (sysRst !== expRst) begin
        failures++;
        $display("FAIL %s sysRst actual=%0b expected=%0b at cycle %0d", reqTag, sysRst, expRst, cycles);
      end
      checks++;
      if (sysRstN !== !expRst) begin
        failures++;
        $display("FAIL R5 sysRstN actual=%0b expected=%0b at cycle %0d", sysRstN, !expRst, cycles);
      end
      checks++;
      if (secFailN !== !sB) begin
        failures++;
        $display("FAIL R6/R8 secFailN actual=%0b expected=%0b at cycle %0d", secFailN, !sB, cycles);
      end
    end
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dropAndRecover(int lowCycles);
    @(negedge clk) priLowRaw = 1'b1;
    waitCycles(lowCycles);
    @(negedge clk) priLowRaw = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0; priLowRaw = 1'b1; secLowRaw = 1'b1; timeoutSel = 2'b00; msTick = 1'b0;
    pA = 1; pB = 1; sA = 1; sB = 1; released = 0; timing = 0; ticks = 0; goal = 50; expRst = 1;
    waitCycles(3);
    // reset state: sysRst=1, sysRstN=0, secFailN=0 (R4)
    checks++;
    if (sysRst !== 1'b1 || sysRstN !== 1'b0 || secFailN !== 1'b0) begin
      failures++;
      $display("FAIL R4 reset state actual=%0b%0b%0b expected=100", sysRst, sysRstN, secFailN);
    end
    @(negedge clk) rstN = 1'b1;
    reqTag = "R1";
    waitCycles(20);
    reqTag = "R4";
    @(negedge clk) priLowRaw = 1'b0;
    waitCycles(50 * TICK_DIV + 40);

    // secondary rail patterns, including a one-cycle pulse
    reqTag = "R6";
    @(negedge clk) secLowRaw = 1'b0;
    waitCycles(7);
    @(negedge clk) secLowRaw = 1'b1;
    @(negedge clk) secLowRaw = 1'b0;
    waitCycles(5);
    @(negedge clk) secLowRaw = 1'b1;
    waitCycles(3);
    @(negedge clk) secLowRaw = 1'b0;
    waitCycles(5);

    // every select code
    for (int s = 1; s < 4; s++) begin
      reqTag = "R3";
      @(negedge clk) timeoutSel = 2'(s);
      dropAndRecover(10);
      waitCycles(goalFor(2'(s)) * TICK_DIV + 40);
    end

    // glitch low while released
    reqTag = "R1";
    dropAndRecover(0);
    @(negedge clk) secLowRaw = 1'b1;
    waitCycles(3);
    @(negedge clk) secLowRaw = 1'b0;
    waitCycles(20);

    // dip during a running timeout
    reqTag = "R7";
    @(negedge clk) timeoutSel = 2'b01;
    dropAndRecover(10);
    waitCycles(120 * TICK_DIV);
    dropAndRecover(5);
    waitCycles(200 * TICK_DIV + 40);

    // select change mid-period
    reqTag = "R9";
    @(negedge clk) timeoutSel = 2'b00;
    dropAndRecover(10);
    waitCycles(12);
    @(negedge clk) timeoutSel = 2'b11;
    waitCycles(50 * TICK_DIV + 40);
    reqTag = "R2";
    dropAndRecover(10);
    waitCycles(800 * TICK_DIV + 40);

    finishRun();
  end

  initial begin
    waitCycles(100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

endmodule